// File: doc/BRIEF.md
# Conditional Accumulator Modify Unit

This block is the accumulator and flag datapath of a small 16-bit DSP core. It keeps a 32-bit accumulator and a 16-bit status word whose upper nibble carries four flags: L at bit 12, Z at bit 13, V at bit 14 and N at bit 15. Each cycle with a valid operation, the block does one of three things. It can load the accumulator with no change to the flags. It can add a 32-bit product to the accumulator and refresh the flags. Or it can apply a conditional modify operation.

A modify operation first tests a condition. The condition compares one flag, Z or N, against a polarity bit taken from the opcode. When the test passes, the block applies an arithmetic right shift, a left shift, a negation or an absolute value, and then recomputes Z and N from the result. When the test fails, nothing changes. An unsupported modify code leaves all state alone and raises a one-cycle error pulse.

All state is registered. The effect of an operation presented before a rising clock edge appears on the outputs right after that edge.

Top module: `acc_mod_unit`

## Requirements
- R1: After reset the accumulator is 0, the status word is 0 and illegal_op is low.
- R2: A load (op_kind = 3) puts load_data into the accumulator and leaves the status word unchanged.
- R3: An accumulate (op_kind = 2) adds product to the accumulator modulo 2^32. It then sets Z if the sum is zero; otherwise it clears Z and copies sum bit 31 into N.
- R4: The condition for a modify (op_kind = 1) depends on cond_sel. Code 0 always passes. Code 5 passes when Z (status bit 13) equals cond_pol. Code 7 passes when N (status bit 15) equals cond_pol. Every other code fails.
- R5: A modify whose condition fails leaves both the accumulator and the status word unchanged.
- R6: Modify code 2 (mod_sel) shifts the accumulator right by one and keeps bit 31 as the sign.
- R7: Modify code 3 shifts the accumulator left by one. The old bit 31 is lost and bit 0 becomes 0.
- R8: Modify code 6 replaces the accumulator with its two's-complement negation.
- R9: Modify code 7 negates the accumulator only if bit 31 is set. The value 0x80000000 maps to itself.
- R10: After a passing modify, Z is 1 exactly when the new accumulator is zero, and N is the new bit 31 when the accumulator is nonzero and 0 otherwise.
- R11: A modify with mod_sel in {0,1,4,5} changes neither the accumulator nor the status word, whatever the condition. It drives illegal_op high for exactly the one cycle after the edge that took the operation.
- R12: Status bits 12 (L), 14 (V) and 11:0 are always zero.
- R13: With op_valid low, or with op_kind = 0, the accumulator and status word keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 2 | 0 none, 1 modify, 2 accumulate, 3 load |
| cond_sel | input | 4 | Condition code for modify |
| cond_pol | input | 1 | Flag polarity the condition compares against |
| mod_sel | input | 3 | Modify operation code |
| product | input | 32 | Product value added by accumulate |
| load_data | input | 32 | Value written by load |
| acc | output | 32 | Accumulator |
| status | output | 16 | Status word with flags in bits 15:12 |
| illegal_op | output | 1 | One-cycle pulse on an unsupported modify code |

## Verification
The bench targets the corners where the modify operations differ from naive arithmetic. It takes the absolute value of 0x80000000, which a wrong design would saturate or turn positive. It right-shifts negative values, which a logical shift would turn positive. It left-shifts with bit 31 set, where the carried-out bit must vanish. It checks that a load following a flag-setting operation leaves stale flags in place; a design that refreshed flags on load would fail there. It also checks that the undefined condition codes block the update and that unsupported modify codes pulse the error output without touching state.

// File: rtl/acc_mod_pkg.sv
package acc_mod_pkg;
    typedef enum logic [1:0] {
        KIND_NONE   = 2'd0,
        KIND_MODIFY = 2'd1,
        KIND_ACCUM  = 2'd2,
        KIND_LOAD   = 2'd3
    } op_kind_e;

    localparam int STATUS_W = 16;
    localparam int FLAG_L   = 12;
    localparam int FLAG_Z   = 13;
    localparam int FLAG_V   = 14;
    localparam int FLAG_N   = 15;

    localparam logic [3:0] COND_ALWAYS = 4'd0;
    localparam logic [3:0] COND_ZERO   = 4'd5;
    localparam logic [3:0] COND_SIGN   = 4'd7;

    localparam logic [2:0] MOD_ASR = 3'd2;
    localparam logic [2:0] MOD_SHL = 3'd3;
    localparam logic [2:0] MOD_NEG = 3'd6;
    localparam logic [2:0] MOD_ABS = 3'd7;
endpackage

// File: rtl/acc_cond_eval.sv
module acc_cond_eval
    import acc_mod_pkg::*;
(
    input  logic [3:0] cond_sel,
    input  logic       cond_pol,
    input  logic       flag_z,
    input  logic       flag_n,
    output logic       pass
);
    always_comb begin
        case (cond_sel)
            COND_ALWAYS: pass = 1'b1;
            COND_ZERO:   pass = (flag_z == cond_pol);
            COND_SIGN:   pass = (flag_n == cond_pol);
            default:     pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc_modify_alu.sv
module acc_modify_alu
    import acc_mod_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2:0]   mod_sel,
    input  logic [W-1:0] operand,
    output logic [W-1:0] result,
    output logic         supported
);
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] negated;
    assign negated = ~operand + {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        supported = 1'b1;
        result    = operand;
        case (mod_sel)
            MOD_ASR: result = {operand[W-1], operand[W-1:1]};
            MOD_SHL: result = {operand[W-2:0], 1'b0};
            MOD_NEG: result = negated;
            MOD_ABS: result = operand[W-1] ? negated : operand;
            default: supported = 1'b0;
        endcase
    end

    // An absolute value can only come out negative for the most negative input
    always_comb begin
        if (mod_sel == MOD_ABS && result[W-1]) begin
            p_abs_min_only_r9: assert (operand == MIN_NEG)
                else $error("abs produced a negative result from a non-minimum input");
        end
    end
endmodule

// File: rtl/acc_mod_unit.sv
module acc_mod_unit
    import acc_mod_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [1:0]          op_kind,
    input  logic [3:0]          cond_sel,
    input  logic                cond_pol,
    input  logic [2:0]          mod_sel,
    input  logic [ACC_W-1:0]    product,
    input  logic [ACC_W-1:0]    load_data,
    output logic [ACC_W-1:0]    acc,
    output logic [STATUS_W-1:0] status,
    output logic                illegal_op
);
    localparam int LOW_SPARE = FLAG_L;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             z;
        logic             n;
        logic             illegal;
    } state_t;

    state_t state_d, state_q;

    logic             cond_pass;
    logic [ACC_W-1:0] mod_result;
    logic             mod_ok;
    logic [ACC_W-1:0] sum;

    acc_cond_eval u_cond (
        .cond_sel (cond_sel),
        .cond_pol (cond_pol),
        .flag_z   (state_q.z),
        .flag_n   (state_q.n),
        .pass     (cond_pass)
    );

    acc_modify_alu #(.W(ACC_W)) u_alu (
        .mod_sel   (mod_sel),
        .operand   (state_q.acc),
        .result    (mod_result),
        .supported (mod_ok)
    );

    assign sum = state_q.acc + product;

    always_comb begin
        state_d         = state_q;
        state_d.illegal = 1'b0;
        if (op_valid) begin
            case (op_kind_e'(op_kind))
                KIND_MODIFY: begin
                    if (!mod_ok) begin
                        state_d.illegal = 1'b1;
                    end else if (cond_pass) begin
                        state_d.acc = mod_result;
                        state_d.z   = ~|mod_result;
                        state_d.n   = (|mod_result) & mod_result[ACC_W-1];
                    end
                end
                KIND_ACCUM: begin
                    state_d.acc = sum;
                    state_d.z   = ~|sum;
                    state_d.n   = (|sum) & sum[ACC_W-1];
                end
                KIND_LOAD: begin
                    state_d.acc = load_data;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign acc        = state_q.acc;
    assign illegal_op = state_q.illegal;
    assign status     = {state_q.n, 1'b0, state_q.z, 1'b0, {LOW_SPARE{1'b0}}};

    p_load_keeps_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == KIND_LOAD) |=> (acc == $past(load_data)) && $stable(status));

    p_accum_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == KIND_ACCUM) |=> acc == $past(acc) + $past(product));

    p_zn_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[FLAG_Z] && status[FLAG_N]));

    p_spare_bits_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !status[FLAG_L] && !status[FLAG_V] && status[LOW_SPARE-1:0] == '0);

    p_illegal_no_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> $stable(acc) && $stable(status));

    p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_kind == KIND_NONE) |=> $stable(acc) && $stable(status) && !illegal_op);
endmodule

// File: tb/acc_mod_unit_test.sv
module acc_mod_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'd0;
    logic [3:0]  cond_sel = 4'd0;
    logic        cond_pol = 1'b0;
    logic [2:0]  mod_sel = 3'd0;
    logic [31:0] product = '0;
    logic [31:0] load_data = '0;
    logic [31:0] acc;
    logic [15:0] status;
    logic        illegal_op;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] m_acc = '0;
    logic        m_z = 1'b0;
    logic        m_n = 1'b0;
    logic        m_ill = 1'b0;
    bit          done = 1'b0;

    acc_mod_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .cond_sel(cond_sel), .cond_pol(cond_pol), .mod_sel(mod_sel),
        .product(product), .load_data(load_data),
        .acc(acc), .status(status), .illegal_op(illegal_op)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] exp_mod(input logic [2:0] s, input logic [31:0] a);
        case (s)
            3'd2: return {a[31], a[31:1]};
            3'd3: return {a[30:0], 1'b0};
            3'd6: return -a;
            3'd7: return a[31] ? -a : a;
            default: return a;
        endcase
    endfunction

    function automatic bit exp_cond(input logic [3:0] c, input logic p, input logic z, input logic n);
        if (c == 4'd0) return 1'b1;
        if (c == 4'd5) return z == p;
        if (c == 4'd7) return n == p;
        return 1'b0;
    endfunction

    function automatic bit mod_known(input logic [2:0] s);
        return s == 3'd2 || s == 3'd3 || s == 3'd6 || s == 3'd7;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] want);
        n_checks++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, got, want);
        end
    endtask

    task automatic step(input logic v, input logic [1:0] k, input logic [3:0] c, input logic p,
                        input logic [2:0] s, input logic [31:0] prod, input logic [31:0] ld);
        string tag;
        @(negedge clk);
        op_valid = v; op_kind = k; cond_sel = c; cond_pol = p;
        mod_sel = s; product = prod; load_data = ld;
        tag = "R13";
        m_ill = 1'b0;
        if (v) begin
            case (k)
                2'd1: begin
                    if (!mod_known(s)) begin
                        m_ill = 1'b1; tag = "R11";
                    end else if (exp_cond(c, p, m_z, m_n)) begin
                        m_acc = exp_mod(s, m_acc);
                        m_z = (m_acc == 0);
                        m_n = (m_acc != 0) && m_acc[31];
                        tag = (s == 3'd2) ? "R6" : (s == 3'd3) ? "R7" : (s == 3'd6) ? "R8" : "R9";
                    end else begin
                        tag = "R5";
                    end
                end
                2'd2: begin
                    m_acc = m_acc + prod;
                    m_z = (m_acc == 0);
                    m_n = (m_acc != 0) && m_acc[31];
                    tag = "R3";
                end
                2'd3: begin
                    m_acc = ld; tag = "R2";
                end
                default: ;
            endcase
        end
        @(posedge clk);
        #2;
        check({tag, " acc"}, acc, m_acc);
        check({tag, "/R10/R4 status"}, {16'h0, status}, {16'h0, m_n, 1'b0, m_z, 13'h0});
        check("R11 illegal_op", {31'h0, illegal_op}, {31'h0, m_ill});
        check("R12 spare status bits", {16'h0, status & 16'h5FFF}, 32'h0);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset acc", acc, 32'h0);
        check("R1 reset status", {16'h0, status}, 32'h0);
        check("R1 reset illegal", {31'h0, illegal_op}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed corners
        step(1, 2'd3, 0, 0, 0, 0, 32'h8000_0000);   // R2 load, flags stay
        step(1, 2'd1, 0, 0, 3'd7, 0, 0);             // R9 abs of min stays
        step(1, 2'd3, 0, 0, 0, 0, 32'hF000_0004);
        step(1, 2'd1, 0, 0, 3'd2, 0, 0);             // R6 arithmetic shift of negative
        step(1, 2'd3, 0, 0, 0, 0, 32'h8000_0001);
        step(1, 2'd1, 0, 0, 3'd3, 0, 0);             // R7 top bit lost
        step(1, 2'd1, 4'd5, 1'b0, 3'd6, 0, 0);       // R4 Z==0 passes, negate
        step(1, 2'd3, 0, 0, 0, 0, 32'h0);            // load zero, flags keep
        step(1, 2'd1, 4'd7, 1'b1, 3'd6, 0, 0);       // R4 N==1 passes
        step(1, 2'd1, 4'd3, 1'b0, 3'd6, 0, 0);       // R4 undefined code fails: R5
        step(1, 2'd3, 0, 0, 0, 0, 32'h0000_0005);
        step(1, 2'd2, 0, 0, 0, 32'hFFFF_FFFB, 0);    // R3 sum to zero sets Z
        step(1, 2'd1, 4'd5, 1'b0, 3'd2, 0, 0);       // Z==0 false: R5
        step(1, 2'd1, 4'd0, 1'b0, 3'd6, 0, 0);       // negate zero, Z stays
        for (int s = 0; s < 6; s++)
            if (s == 0 || s == 1 || s == 4 || s == 5)
                step(1, 2'd1, 4'd0, 1'b0, 3'(s), 0, 0);  // R11 unsupported codes
        step(0, 2'd3, 0, 0, 0, 0, 32'h1234_5678);    // R13 invalid op ignored
        step(1, 2'd0, 0, 0, 0, 0, 32'h1234_5678);    // R13 kind none ignored

        // Constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            logic [3:0]  c;
            r = $urandom;
            c = (r[3:2] == 2'd0) ? 4'd0 : (r[3:2] == 2'd1) ? 4'd5 :
                (r[3:2] == 2'd2) ? 4'd7 : r[7:4];
            step(r[8] | r[9], r[11:10], c, r[12], r[15:13], $urandom, $urandom);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule